// File: doc/BRIEF.md
# Multi-Lane Deterministic-Latency Release Buffer

This block sits on the receive side of a multi-lane serial converter link, after lane alignment. Each lane writes one frame word per frame clock into a small FIFO of its own. Writing starts with the first word the lane marks valid after a link reset. A local frame counter runs freely and defines a multiframe of K frames. A single-cycle SYSREF pulse sets the counter's phase. The counter is not affected by link resets.

Reading does not start when data is present. All lanes start reading together, and only at a release point: the frame position given by a programmable release delay, counted from the multiframe boundary. A release point is used only if every lane has already arrived. Otherwise it is skipped and the next multiframe's release point is used. Lanes that arrive early are held until then. If the arrival phase relative to the local multiframe is the same on every startup, the output appears at the same cycle every time. The delay from link to output can exceed one multiframe.

Frame clock equals the block clock: one word per lane per cycle.

Top module: `lane_release_buffer`

## Requirements
- R1: `lmfc_o` is 0 after reset. It counts up by one per clock and returns to 0 after reaching `mf_len_m1_i`, which gives K = `mf_len_m1_i` + 1 frames per multiframe.
- R2: A one-cycle `sysref_i` pulse makes `lmfc_o` equal 0 on the next cycle. A pulse given while `lmfc_o` equals `mf_len_m1_i` leaves the count sequence unchanged.
- R3: The effective release position is `rbd_i`, or `mf_len_m1_i` when `rbd_i` is larger. In the cycle where `valid_o` rises, `lmfc_o` equals that position.
- R4: `valid_o` rises at the first cycle that meets both conditions: every `arrived_o` bit is already set, and `lmfc_o` is at the release position. A release position reached before the last lane has arrived is skipped.
- R5: `arrived_o[i]` is set on the cycle after lane i's first valid word is written. It stays set until a link reset.
- R6: In the first valid cycle, lane i's field `data_o[i*DW +: DW]` holds lane i's first written word. Each later cycle presents the lane's next word, with all lanes in lockstep. `valid_o` stays high until a link reset.
- R7: Suppose link resets occur at the same multiframe phase and the lane delays are the same. Then the release cycle, counted from the reset, is the same every time. If the release position lies where the last arrival varies by one cycle, the release cycle moves by exactly K.
- R8: If a lane writes while its FIFO holds DEPTH words and is not being read, `overflow_o[i]` becomes set. It stays set, and no release happens, until a link reset.
- R9: A `link_rst_i` cycle clears `valid_o`, `arrived_o`, `overflow_o` and the FIFO contents. It does not disturb `lmfc_o`.
- R10: During and just after reset, `valid_o`, `arrived_o`, `overflow_o`, `data_o` and `lmfc_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Frame clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_rst_i | input | 1 | Synchronous link reset; clears the buffers and the release state |
| sysref_i | input | 1 | One-cycle alignment pulse for the frame counter |
| mf_len_m1_i | input | KW | Frames per multiframe minus one |
| rbd_i | input | KW | Release delay in frames after the multiframe boundary |
| lane_vld_i | input | LANES | Per-lane word valid; the first one marks start of data |
| lane_data_i | input | LANES*DW | Per-lane words; lane i at bits [i*DW +: DW] |
| data_o | output | LANES*DW | Released words, same packing; zero when not valid |
| valid_o | output | 1 | Released data valid |
| lmfc_o | output | KW | Current frame position in the multiframe |
| arrived_o | output | LANES | Per-lane arrived flags |
| overflow_o | output | LANES | Sticky per-lane overflow flags |

## Verification
The bench uses LANES=4, DW=8, DEPTH=16 and KW=5. It drives K values from 1 to 8 and lane delays of up to six cycles, so the worst buffer fill of 14 words stays just under the depth. A directed case holds three lanes back for 50 cycles to force an overflow. These settings reach the clamp of the release delay (including K=1), a release point skipped because of a late lane, and the one-multiframe shift when the last arrival moves by a cycle. Eight-bit words carry the lane number and a word index, so ordering and lockstep errors can be seen at the output.

// File: rtl/lrb_pkg.sv
`timescale 1ns/1ps
package lrb_pkg;
  function automatic int unsigned clamp_hi(int unsigned v, int unsigned hi);
    return (v > hi) ? hi : v;
  endfunction
endpackage

// File: rtl/lrb_lmfc.sv
`timescale 1ns/1ps
module lrb_lmfc #(
  parameter int KW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sysref_i,
  input  logic [KW-1:0] len_m1_i,
  output logic [KW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (sysref_i)          cnt_o <= '0;
    else if (cnt_o >= len_m1_i) cnt_o <= '0;
    else                        cnt_o <= cnt_o + 1'b1;
  end

  // R2
  sysref_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysref_i |=> (cnt_o == '0));
  // R1
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sysref_i && cnt_o == len_m1_i) |=> (cnt_o == '0));
  // R1
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sysref_i && cnt_o < len_m1_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/lrb_lane_fifo.sv
`timescale 1ns/1ps
module lrb_lane_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          arrived_o,
  output logic          ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, rd_ok, wr_ok;

  assign full  = (cnt_q == CW'(DEPTH));
  assign rd_ok = rd_i && (cnt_q != '0);
  assign wr_ok = wr_i && (!full || rd_ok);
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0; rptr_q <= '0; cnt_q <= '0;
      arrived_o <= 1'b0; ovf_o <= 1'b0;
    end else if (clr_i) begin
      wptr_q <= '0; rptr_q <= '0; cnt_q <= '0;
      arrived_o <= 1'b0; ovf_o <= 1'b0;
    end else begin
      if (wr_ok) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (rd_ok) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
      if (wr_i) arrived_o <= 1'b1;
      if (wr_i && full && !rd_i) ovf_o <= 1'b1;
    end
  end

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);
  // R5
  arrive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> arrived_o);
endmodule

// File: rtl/lrb_release.sv
`timescale 1ns/1ps
module lrb_release #(
  parameter int LANES = 4,
  parameter int KW    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [LANES-1:0] arrived_i,
  input  logic [LANES-1:0] ovf_i,
  input  logic [KW-1:0]    cnt_i,
  input  logic [KW-1:0]    rbd_i,
  input  logic [KW-1:0]    len_m1_i,
  output logic             rd_o
);
  logic          released_q, fire;
  logic [KW-1:0] rbd_eff;

  assign rbd_eff = KW'(lrb_pkg::clamp_hi(32'(rbd_i), 32'(len_m1_i)));
  assign fire    = !released_q && (&arrived_i) && !(|ovf_i) && (cnt_i == rbd_eff);
  assign rd_o    = released_q || fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     released_q <= 1'b0;
    else if (clr_i)  released_q <= 1'b0;
    else if (fire)   released_q <= 1'b1;
  end

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (released_q && !clr_i) |=> released_q);
endmodule

// File: rtl/lane_release_buffer.sv
`timescale 1ns/1ps
module lane_release_buffer #(
  parameter int LANES = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int KW    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                link_rst_i,
  input  logic                sysref_i,
  input  logic [KW-1:0]       mf_len_m1_i,
  input  logic [KW-1:0]       rbd_i,
  input  logic [LANES-1:0]    lane_vld_i,
  input  logic [LANES*DW-1:0] lane_data_i,
  output logic [LANES*DW-1:0] data_o,
  output logic                valid_o,
  output logic [KW-1:0]       lmfc_o,
  output logic [LANES-1:0]    arrived_o,
  output logic [LANES-1:0]    overflow_o
);
  logic [KW-1:0] cnt;
  logic          rd;
  logic [DW-1:0] rdata [LANES];

  lrb_lmfc #(.KW(KW)) u_lmfc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sysref_i (sysref_i),
    .len_m1_i (mf_len_m1_i),
    .cnt_o    (cnt)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lrb_lane_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (link_rst_i),
      .wr_i      (lane_vld_i[g]),
      .wdata_i   (lane_data_i[g*DW +: DW]),
      .rd_i      (rd),
      .rdata_o   (rdata[g]),
      .arrived_o (arrived_o[g]),
      .ovf_o     (overflow_o[g])
    );
    assign data_o[g*DW +: DW] = rd ? rdata[g] : '0;
  end

  lrb_release #(.LANES(LANES), .KW(KW)) u_release (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (link_rst_i),
    .arrived_i (arrived_o),
    .ovf_i     (overflow_o),
    .cnt_i     (cnt),
    .rbd_i     (rbd_i),
    .len_m1_i  (mf_len_m1_i),
    .rd_o      (rd)
  );

  assign valid_o = rd;
  assign lmfc_o  = cnt;

  // R3
  release_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (lmfc_o == ((rbd_i > mf_len_m1_i) ? mf_len_m1_i : rbd_i)));
  // R4
  all_arrived_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (&arrived_o));
  // R8
  ovf_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|overflow_o) |-> !$rose(valid_o));
  // R6
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !link_rst_i) |=> valid_o);
endmodule

// File: tb/lane_release_buffer_bench.sv
`timescale 1ns/1ps
module lane_release_buffer_bench;
  localparam int LANES = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int KW    = 5;
  localparam int LAST  = 60;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                link_rst = 1'b0;
  logic                sysref = 1'b0;
  logic [KW-1:0]       mf_len = '0;
  logic [KW-1:0]       rbd_r = '0;
  logic [LANES-1:0]    lane_vld = '0;
  logic [LANES*DW-1:0] lane_data = '0;
  logic [LANES*DW-1:0] data_o;
  logic                valid_o;
  logic [KW-1:0]       lmfc_o;
  logic [LANES-1:0]    arrived_o, overflow_o;

  int tests = 0, fails = 0;
  int dly [LANES];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_release_buffer #(.LANES(LANES), .DW(DW), .DEPTH(DEPTH), .KW(KW)) u_lane_release_buffer (
    .clk_i(clk), .rst_ni(rst_n), .link_rst_i(link_rst), .sysref_i(sysref),
    .mf_len_m1_i(mf_len), .rbd_i(rbd_r), .lane_vld_i(lane_vld), .lane_data_i(lane_data),
    .data_o(data_o), .valid_o(valid_o), .lmfc_o(lmfc_o),
    .arrived_o(arrived_o), .overflow_o(overflow_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int exp_release(input int l0, input int kk, input int eff, input int amax);
    int e;
    e = ((eff - (l0 + amax + 1)) % kk + kk) % kk;
    return amax + 1 + e;
  endfunction

  task automatic trial(input int km1, input int rbd, output int rel);
    int kk, eff, l0, amax, exp_rel, rel_lmfc, arr_bad, dat_bad, vld_bad;
    bit ovf_any;
    logic [LANES-1:0] exp_ovf;
    kk = km1 + 1;
    eff = (rbd > km1) ? km1 : rbd;
    mf_len = KW'(km1); rbd_r = KW'(rbd); lane_vld = '0; lane_data = '0;
    step();
    while (lmfc_o != '0) step();
    link_rst = 1'b1; step(); link_rst = 1'b0;
    l0 = int'(lmfc_o);
    // R9: link reset leaves the frame counter running
    chk(l0 == (1 % kk), "R9 lmfc", l0, 1 % kk);
    chk(!valid_o && arrived_o == '0 && overflow_o == '0, "R9 cleared",
        int'({valid_o, arrived_o, overflow_o}), 0);
    amax = 0;
    for (int i = 0; i < LANES; i++) if (dly[i] > amax) amax = dly[i];
    exp_rel = exp_release(l0, kk, eff, amax);
    ovf_any = 1'b0;
    for (int i = 0; i < LANES; i++) if (exp_rel - 1 - dly[i] >= DEPTH) ovf_any = 1'b1;
    for (int i = 0; i < LANES; i++)
      exp_ovf[i] = ovf_any && (LAST + 1 >= dly[i] + DEPTH + 1);
    if (ovf_any) exp_rel = -1;
    rel = -1; rel_lmfc = -1; arr_bad = 0; dat_bad = 0; vld_bad = 0;
    for (int c = 0; c <= LAST; c++) begin
      for (int i = 0; i < LANES; i++) begin
        lane_vld[i] = (c >= dly[i]);
        lane_data[i*DW +: DW] = (c >= dly[i]) ? {2'(i), 6'(c - dly[i])} : '0;
      end
      #1;
      for (int i = 0; i < LANES; i++)
        if (arrived_o[i] != (c >= dly[i] + 1)) arr_bad++;
      if (valid_o && rel < 0) begin rel = c; rel_lmfc = int'(lmfc_o); end
      if (rel >= 0) begin
        if (!valid_o) vld_bad++;
        for (int i = 0; i < LANES; i++)
          if (data_o[i*DW +: DW] != {2'(i), 6'(c - rel)}) dat_bad++;
      end
      step();
    end
    chk(rel == exp_rel, "R4 release cycle", rel, exp_rel);
    if (rel >= 0) begin
      chk(rel_lmfc == eff, "R3 release position", rel_lmfc, eff);
      chk(dat_bad == 0, "R6 lockstep data", dat_bad, 0);
      chk(vld_bad == 0, "R6 valid held", vld_bad, 0);
    end
    chk(arr_bad == 0, "R5 arrived flags", arr_bad, 0);
    chk(overflow_o == exp_ovf, "R8 overflow flags", int'(overflow_o), int'(exp_ovf));
    lane_vld = '0; lane_data = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int r1, r2, r3, bad, prev;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    // R10: reset state
    chk(!valid_o && arrived_o == '0 && overflow_o == '0 && data_o == '0 && lmfc_o == '0,
        "R10 reset", int'(lmfc_o), 0);
    #1 rst_n = 1'b1;
    chk(!valid_o && lmfc_o == '0, "R10 after reset", int'(lmfc_o), 0);

    // R1: count and wrap with K=5
    mf_len = 5'd4; step();
    while (lmfc_o != '0) step();
    bad = 0;
    for (int n = 0; n < 20; n++) begin
      prev = int'(lmfc_o); step();
      if (int'(lmfc_o) != (prev + 1) % 5) bad++;
    end
    chk(bad == 0, "R1 count sequence", bad, 0);

    // R2: realign and matching-phase pulse
    mf_len = 5'd7; step();
    while (lmfc_o != 5'd3) step();
    sysref = 1'b1; step(); sysref = 1'b0;
    chk(lmfc_o == '0, "R2 realign", int'(lmfc_o), 0);
    while (lmfc_o != 5'd7) step();
    sysref = 1'b1; step(); sysref = 1'b0;
    chk(lmfc_o == '0, "R2 matching pulse", int'(lmfc_o), 0);
    step();
    chk(lmfc_o == 5'd1, "R2 sequence kept", int'(lmfc_o), 1);

    // R7: repeatability across link resets
    dly = '{3, 5, 2, 4};
    trial(7, 2, r1); trial(7, 2, r2); trial(7, 2, r3);
    chk(r1 == r2 && r2 == r3, "R7 repeat latency", r3, r1);

    // R7: good release point absorbs one-cycle arrival jitter
    dly = '{3, 5, 2, 5}; trial(7, 2, r1);
    dly = '{3, 5, 2, 6}; trial(7, 2, r2);
    chk(r1 == r2, "R7 good position stable", r2, r1);
    // R7: bad release point shifts by one multiframe
    dly = '{3, 5, 2, 5}; trial(7, 7, r1);
    dly = '{3, 5, 2, 6}; trial(7, 7, r2);
    chk(r2 - r1 == 8, "R7 bad position shift", r2 - r1, 8);

    // R3: clamp, including K=1
    dly = '{1, 0, 4, 2}; trial(5, 20, r1);
    dly = '{0, 2, 1, 3}; trial(0, 3, r1);

    // R8: lane 0 overflows while others are late; R9 clears it next trial
    dly = '{0, 50, 50, 50}; trial(7, 0, r1);
    chk(r1 == -1, "R8 no release after overflow", r1, -1);

    // constrained random trials
    for (int t = 0; t < 16; t++) begin
      for (int i = 0; i < LANES; i++) dly[i] = int'($urandom_range(6, 0));
      trial(int'($urandom_range(7, 0)), int'($urandom_range(11, 0)), r1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule